// File: doc/BRIEF.md
# PCM Port Reset, Initialisation and Bypass Controller

This block sits between the pins of a two-port PCM voice processor and its processing core. It sequences power-down, recovery from reset and a bit-exact bypass path. While the active-low reset input is low, the block does four things: it stops the core with its clock-enable, turns off the output enables of both serial data outputs, forces the data outputs to zero and refuses register writes. After reset is released, the block counts whole 8 kHz frames. The defaults load while it counts. Once eight complete frames have passed, it raises a ready flag that admits register writes. A write attempted earlier is dropped and flagged with a one-cycle error pulse.

Each port carries one sample per frame, captured on the frame strobe. On the processed path, the core's voice results reach the outputs two frames after capture. The D/C signalling byte passes with one frame of delay. When the bypass bit is set, each port's input sample is copied unchanged to its paired output and the core clock-enable is dropped to save power. The bypass selection changes only at a frame strobe, so no frame is split between the two paths.

Top module: `pcm_init_bypass_ctl`

## Requirements
- R1: On the cycle after rst_n is sampled low, core_ce, out_oe, regs_ready, byp_active, wr_accept, wr_err, rx_out, tx_out and dc_out are all 0.
- R2: From the cycle after rst_n is first sampled high, out_oe is 2'b11, where bit 0 enables rx_out and bit 1 enables tx_out.
- R3: The first frame_stb after release only marks the start of a complete frame. regs_ready rises on the cycle after the ninth frame_stb sampled with rst_n high, and it stays high until reset.
- R4: A wr_req sampled while regs_ready is 1 gives a one-cycle wr_accept on the next cycle. A wr_req sampled while regs_ready is 0 gives no wr_accept and a one-cycle wr_err instead.
- R5: byp_active changes only on the cycle after a frame_stb. It then takes the byp_req value sampled with that strobe, and byp_req at any other time has no effect.
- R6: Out of reset, core_ce is 1 exactly when byp_active is 0.
- R7: At a frame_stb with byp_req 1, rx_out takes rx_in and tx_out takes tx_in, bit for bit, from the next cycle on.
- R8: At a frame_stb with byp_req 0, rx_out takes the proc_rx value that was sampled two strobes earlier, and tx_out likewise takes proc_tx. Values not yet sampled since reset count as 0.
- R9: At every frame_stb, dc_out takes the dc_in value sampled at the previous strobe, or 0 if there was none since reset.
- R10: rx_out, tx_out and dc_out hold their values between frame strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset/power-down request, sampled synchronously |
| frame_stb | input | 1 | One-cycle pulse at each 8 kHz frame boundary |
| byp_req | input | 1 | Bypass control bit from the register interface |
| wr_req | input | 1 | Register write request |
| rx_in | input | W | Receive-port input sample |
| tx_in | input | W | Send-port input sample |
| proc_rx | input | W | Core-processed receive sample |
| proc_tx | input | W | Core-processed send sample |
| dc_in | input | DC_W | D/C signalling byte |
| core_ce | output | 1 | Processing core clock-enable |
| out_oe | output | 2 | Serial output enables {tx, rx} |
| regs_ready | output | 1 | Register writes allowed |
| wr_accept | output | 1 | Write forwarded to the registers |
| wr_err | output | 1 | Early write dropped (pulse) |
| byp_active | output | 1 | Path select: bypass in effect |
| rx_out | output | W | Receive-port output sample |
| tx_out | output | W | Send-port output sample |
| dc_out | output | DC_W | Delayed D/C byte |

## Verification
Several properties are checked on every cycle by the assertions. After reset, outputs and enables are quiet. Out of reset, both output enables are on. The ready flag never falls except through reset, and it never rises before nine strobes have been counted. A write is accepted only when ready was set, and an error pulse follows only from an early write. The bypass select moves only after a strobe, and the core enable is the opposite of it. The data relations need the bench's scenarios, because each depends on values sampled one or two frames earlier. These are the exact pass-through in bypass, the two-frame voice latency, the one-frame D/C latency and the holding of outputs between strobes. The bench's scenarios also cover the partial frame before the first strobe and the strobe that coincides with reset release.

// File: rtl/pib_pkg.sv
package pib_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_SOF = 2'd0,
    ST_COUNT    = 2'd1,
    ST_READY    = 2'd2
  } init_st_t;
endpackage

// File: rtl/pib_init_seq.sv
module pib_init_seq #(
  parameter int INIT_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  output logic live,
  output logic ready
);
  import pib_pkg::*;
  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_FRAMES - 1);

  init_st_t      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_WAIT_SOF;
      cnt  <= '0;
      live <= 1'b0;
    end else begin
      live <= 1'b1;
      case (st)
        ST_WAIT_SOF: if (frame_stb) st <= ST_COUNT;
        ST_COUNT: if (frame_stb) begin
          if (cnt == LAST) begin
            st  <= ST_READY;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_READY;
      endcase
    end
  end

  assign ready = (st == ST_READY);
endmodule

// File: rtl/pib_wr_gate.sv
module pib_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic ready,
  output logic wr_accept,
  output logic wr_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_accept <= 1'b0;
      wr_err    <= 1'b0;
    end else begin
      wr_accept <= wr_req & ready;
      wr_err    <= wr_req & ~ready;
    end
  end
endmodule

// File: rtl/pib_mode_sel.sv
module pib_mode_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_stb,
  input  logic byp_req,
  output logic byp_q,
  output logic core_ce
);
  logic byp_nx;

  always_comb byp_nx = frame_stb ? byp_req : byp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q   <= 1'b0;
      core_ce <= 1'b0;
    end else begin
      byp_q   <= byp_nx;
      core_ce <= ~byp_nx;
    end
  end
endmodule

// File: rtl/pib_frame_dly.sv
module pib_frame_dly #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (frame_stb) begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/pcm_init_bypass_ctl.sv
module pcm_init_bypass_ctl #(
  parameter int W           = 16,
  parameter int DC_W        = 8,
  parameter int INIT_FRAMES = 8,
  parameter int VOICE_LAT   = 2,
  parameter int DC_LAT      = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic            byp_req,
  input  logic            wr_req,
  input  logic [W-1:0]    rx_in,
  input  logic [W-1:0]    tx_in,
  input  logic [W-1:0]    proc_rx,
  input  logic [W-1:0]    proc_tx,
  input  logic [DC_W-1:0] dc_in,
  output logic            core_ce,
  output logic [1:0]      out_oe,
  output logic            regs_ready,
  output logic            wr_accept,
  output logic            wr_err,
  output logic            byp_active,
  output logic [W-1:0]    rx_out,
  output logic [W-1:0]    tx_out,
  output logic [DC_W-1:0] dc_out
);
  localparam int NPORT = 2;

  logic            live_q;
  logic [W-1:0]    pin   [NPORT];
  logic [W-1:0]    pproc [NPORT];
  logic [W-1:0]    pdly  [NPORT];
  logic [W-1:0]    pout  [NPORT];
  logic [DC_W-1:0] dc_dly;

  pib_init_seq #(.INIT_FRAMES(INIT_FRAMES)) u_init (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .live(live_q), .ready(regs_ready)
  );

  pib_wr_gate u_wr (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .ready(regs_ready),
    .wr_accept(wr_accept), .wr_err(wr_err)
  );

  pib_mode_sel u_mode (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .byp_req(byp_req),
    .byp_q(byp_active), .core_ce(core_ce)
  );

  assign out_oe   = {NPORT{live_q}};
  assign pin[0]   = rx_in;
  assign pin[1]   = tx_in;
  assign pproc[0] = proc_rx;
  assign pproc[1] = proc_tx;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pib_frame_dly #(.W(W), .DEPTH(VOICE_LAT)) u_vdly (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .din(pproc[g]), .dout(pdly[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)         pout[g] <= '0;
      else if (frame_stb) pout[g] <= byp_req ? pin[g] : pdly[g];
    end
  end

  assign rx_out = pout[0];
  assign tx_out = pout[1];

  pib_frame_dly #(.W(DC_W), .DEPTH(DC_LAT)) u_dcdly (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .din(dc_in), .dout(dc_dly)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         dc_out <= '0;
    else if (frame_stb) dc_out <= dc_dly;
  end
endmodule

// File: rtl/pib_chk.sv
module pib_chk #(
  parameter int INIT_FRAMES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_stb,
  input logic       wr_req,
  input logic       core_ce,
  input logic [1:0] out_oe,
  input logic       regs_ready,
  input logic       wr_accept,
  input logic       wr_err,
  input logic       byp_active
);
  int stb_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_seen <= 0;
    else if (frame_stb && stb_seen <= INIT_FRAMES) stb_seen <= stb_seen + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!core_ce && out_oe == 2'b00 && !regs_ready && !byp_active && !wr_accept && !wr_err));

  p_oe_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_oe == 2'b11);

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(regs_ready) |-> $past(!rst_n));

  p_ready_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_ready |-> stb_seen > INIT_FRAMES);

  p_acc_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> $past(regs_ready) && $past(wr_req));

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_req) && !$past(regs_ready));

  p_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_err && wr_accept));

  p_byp_on_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && byp_active != $past(byp_active)) |-> $past(frame_stb));

  p_ce_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byp_active |-> !core_ce);

  p_ce_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !byp_active) |-> core_ce);
endmodule

bind pcm_init_bypass_ctl pib_chk #(.INIT_FRAMES(INIT_FRAMES)) u_chk (.*);

// File: tb/sim_pcm_init_bypass_ctl.sv
module sim_pcm_init_bypass_ctl;
  localparam int W = 16, DCW = 8, FR = 16;

  logic clk = 1'b0, rst_n = 1'b0, frame_stb = 1'b0, byp_req = 1'b0, wr_req = 1'b0;
  logic [W-1:0] rx_in = '0, tx_in = '0, proc_rx = '0, proc_tx = '0;
  logic [DCW-1:0] dc_in = '0;
  logic core_ce, regs_ready, wr_accept, wr_err, byp_active;
  logic [1:0] out_oe;
  logic [W-1:0] rx_out, tx_out;
  logic [DCW-1:0] dc_out;

  always #5 clk = ~clk;

  pcm_init_bypass_ctl u0 (.*);

  int nvec = 0, nbad = 0, sc = 0;
  bit done = 0, m_live = 0, m_byp = 0, e_acc = 0, e_err = 0, last_stb = 0;
  logic [W-1:0] prx1 = '0, prx2 = '0, ptx1 = '0, ptx2 = '0, e_rx = '0, e_tx = '0;
  logic [DCW-1:0] dc1 = '0, e_dc = '0;

  function automatic logic [W-1:0] pick(bit byp, logic [W-1:0] raw, logic [W-1:0] old2);
    return byp ? raw : old2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cycle();
    string dtag;
    if (!m_live) begin
      chk("R1 core_ce", 32'(core_ce), 0);
      chk("R1 out_oe", 32'(out_oe), 0);
      chk("R1 ready", 32'(regs_ready), 0);
      chk("R1 byp", 32'(byp_active), 0);
    end else begin
      chk("R2 out_oe", 32'(out_oe), 32'd3);
      chk("R3 ready", 32'(regs_ready), 32'(sc >= 9));
      chk("R5 byp_active", 32'(byp_active), 32'(m_byp));
      chk("R6 core_ce", 32'(core_ce), 32'(!m_byp));
    end
    chk("R4 wr_accept", 32'(wr_accept), 32'(e_acc));
    chk("R4 wr_err", 32'(wr_err), 32'(e_err));
    dtag = !last_stb ? "R10" : (m_byp ? "R7" : "R8");
    if (!m_live) dtag = "R1";
    chk({dtag, " rx_out"}, 32'(rx_out), 32'(e_rx));
    chk({dtag, " tx_out"}, 32'(tx_out), 32'(e_tx));
    chk({(last_stb && m_live) ? "R9" : dtag, " dc_out"}, 32'(dc_out), 32'(e_dc));
  endtask

  task automatic model_clear();
    sc = 0; m_byp = 0; prx1 = '0; prx2 = '0; ptx1 = '0; ptx2 = '0;
    e_rx = '0; e_tx = '0; dc1 = '0; e_dc = '0;
  endtask

  task automatic apply_strobe(bit b);
    rx_in = W'($urandom); tx_in = W'($urandom);
    proc_rx = W'($urandom); proc_tx = W'($urandom); dc_in = DCW'($urandom);
    byp_req = b; frame_stb = 1'b1; wr_req = 1'b0; e_acc = 0; e_err = 0;
    if (m_live) begin
      e_rx = pick(b, rx_in, prx2); e_tx = pick(b, tx_in, ptx2);
      prx2 = prx1; prx1 = proc_rx; ptx2 = ptx1; ptx1 = proc_tx;
      e_dc = dc1; dc1 = dc_in; m_byp = b; sc++;
    end
    last_stb = 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
      frame_stb = 1'b0; last_stb = 0;
      byp_req = 1'($urandom);
      rx_in = W'($urandom); proc_rx = W'($urandom); dc_in = DCW'($urandom);
      wr_req = m_live && ($urandom % 4 == 0);
      e_acc = wr_req && (sc >= 9);
      e_err = wr_req && (sc < 9);
    end
  endtask

  task automatic frame(bit b, int len);
    @(negedge clk);
    check_cycle();
    apply_strobe(b);
    idle(len - 1);
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    check_cycle();
    rst_n = 1'b0; frame_stb = 1'b0; wr_req = 1'b0; e_acc = 0; e_err = 0;
    m_live = 0; last_stb = 0; model_clear();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R1: held in reset from time zero
    do_reset(5);
    // release mid-frame, partial frame before first strobe (R3)
    rst_n = 1'b1; m_live = 1;
    idle(7);
    for (int f = 0; f < 12; f++) begin
      frame(1'($urandom), FR);
      if (f == 7) chk("R3 not ready after 8 strobes", 32'(regs_ready), 0);
      if (f == 8) chk("R3 ready after 9 strobes", 32'(regs_ready), 1);
    end
    // directed bypass toggling R7 R8
    frame(1'b1, FR); frame(1'b1, FR); frame(1'b0, FR); frame(1'b0, FR);
    frame(1'b1, 3); frame(1'b0, 3);
    // random run
    for (int f = 0; f < 150; f++) frame(1'($urandom), 2 + $urandom % FR);
    // reset mid-operation, release coinciding with a strobe
    do_reset(3);
    @(negedge clk);
    check_cycle();
    rst_n = 1'b1; m_live = 1;
    apply_strobe(1'b0);
    idle(FR - 1);
    for (int f = 0; f < 20; f++) begin
      frame(1'($urandom), FR);
      if (f == 6) chk("R3 not ready after 8 strobes (edge release)", 32'(regs_ready), 0);
      if (f == 7) chk("R3 ready after 9 strobes (edge release)", 32'(regs_ready), 1);
    end
    @(negedge clk);
    check_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule